// File: doc/BRIEF.md
# Three-Input Minterm Logic Unit

This block merges three equal-width source words, A, B and C, into one result word, treating every bit position on its own. An 8-bit function code chooses which of the eight product terms of the three inputs contribute to the result. A product term is one specific true/complemented combination of A, B and C. The result is the OR of every product term the code enables. Any two- or three-input Boolean function can be picked this way, for example copy, mask, invert, XOR or overlay.

The unit also tracks a sticky zero flag across a whole operation. An operation begins with a start pulse, which sets the flag. The first valid result word that has any bit set clears the flag, and it stays clear until the next start. The flag does not depend on where the results go, so it can be used to test whether two bitmaps overlap without writing anything. The result is registered, and each valid input word gives one valid result word one cycle later.

Top module: `tri_minterm_rop`

## Requirements
- R1: Bit n of the function code enables product term n. In that term, n[2] selects A, n[1] selects B and n[0] selects C. A 1 uses the input's true value and a 0 uses its complement. For example, code 0x01 gives /A·/B·/C, 0x80 gives A·B·C, 0x04 gives /A·B·/C and 0x20 gives A·/B·C.
- R2: For each bit i, the result bit equals the OR of all enabled product terms evaluated on A[i], B[i] and C[i]. This holds for all 256 function codes.
- R3: Function code 0x0A gives ~A & C at every bit position.
- R4: Function code 0x00 gives all zeros and 0xFF gives all ones, whatever the inputs.
- R5: `res_valid` is high in exactly the cycle after each cycle where `in_valid` is high. `res` then shows that word's result and holds its value while no new word arrives.
- R6: While reset is active (`rst_n` low), `res` is 0, `res_valid` is 0 and `zero_flag` is 1.
- R7: A `start` pulse sets `zero_flag` to 1 at the next edge. A word presented in the same cycle as `start` belongs to the new operation and is judged there.
- R8: `zero_flag` is cleared at the same edge that delivers a valid nonzero result. It then stays 0 until the next `start`, even if later results are zero.
- R9: Cycles with `in_valid` low leave `zero_flag` unchanged, whatever the function code and inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a new operation; sets the zero flag |
| in_valid | input | 1 | Source words and function code are valid |
| func | input | 8 | Minterm enable mask |
| src_a | input | 16 | Source word A |
| src_b | input | 16 | Source word B |
| src_c | input | 16 | Source word C |
| res | output | 16 | Registered result word |
| res_valid | output | 1 | Result word is valid this cycle |
| zero_flag | output | 1 | All results since the last start were zero |

## Verification
The start of a new operation can fall in the same cycle as the arrival of a word. Before that cycle the flag is driven low by a nonzero word. The bench then sends the start together with a nonzero word, and also sends a start together with a zero word. In both cases it checks that the flag reflects only the word that shares the start, so it reads 0 and 1 respectively. A start pulse on its own, and a start right after a nonzero result, are also checked to leave the flag at 1.

// File: rtl/tri_minterm_rop.sv
module tri_minterm_rop #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  input  logic [7:0]       func,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  input  logic [WIDTH-1:0] src_c,
  output logic [WIDTH-1:0] res,
  output logic             res_valid,
  output logic             zero_flag
);

  logic [WIDTH-1:0] mix;
  logic             hit;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign mix[i] = func[{src_a[i], src_b[i], src_c[i]}];
  end

  assign hit = in_valid && (|mix);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res       <= '0;
      res_valid <= 1'b0;
      zero_flag <= 1'b1;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res <= mix;
      if (start)    zero_flag <= !hit;
      else if (hit) zero_flag <= 1'b0;
    end
  end

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  assert_valid_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  assert_res_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res));
  assert_const_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && func == 8'h00) |=> (res == '0));
  assert_const_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && func == 8'hFF) |=> (res == '1));
  assert_start_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in_valid) |=> zero_flag);
  assert_rise_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_flag) |-> $past(start));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !zero_flag) |=> !zero_flag);
  assert_clear_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zero_flag) |-> (res_valid && res != '0));
  assert_idle_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !start) |=> $stable(zero_flag));

endmodule

// File: tb/tri_minterm_rop_test.sv
module tri_minterm_rop_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  func = '0;
  logic [15:0] src_a = '0, src_b = '0, src_c = '0;
  logic [15:0] res;
  logic        res_valid, zero_flag;

  int compared = 0;
  int mismatched = 0;
  logic zmodel = 1'b1;
  logic [15:0] last = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  tri_minterm_rop uut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .func(func),
    .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .res(res), .res_valid(res_valid), .zero_flag(zero_flag)
  );

  function automatic logic [15:0] expect_of(logic [7:0] f, logic [15:0] a, logic [15:0] b, logic [15:0] c);
    logic [15:0] y = '0;
    for (int n = 0; n < 8; n++) begin
      logic [15:0] t;
      t = (n[2] ? a : ~a) & (n[1] ? b : ~b) & (n[0] ? c : ~c);
      if (f[n]) y = y | t;
    end
    return y;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic next16();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic send(string req, logic st, logic [7:0] f, logic [15:0] a, logic [15:0] b, logic [15:0] c);
    logic [15:0] e;
    @(negedge clk);
    start = st; in_valid = 1'b1; func = f; src_a = a; src_b = b; src_c = c;
    e = expect_of(f, a, b, c);
    if (st) zmodel = 1'b1;
    if (e != 0) zmodel = 1'b0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    check(req, {16'h0, res}, {16'h0, e});
    check("R5 valid", {31'h0, res_valid}, 32'h1);
    check("R8 flag", {31'h0, zero_flag}, {31'h0, zmodel});
    last = e;
  endtask

  task automatic idle_cycle(string req, logic st);
    @(negedge clk);
    start = st; in_valid = 1'b0; func = 8'hFF; src_a = lfsr; src_b = ~lfsr; src_c = 16'h1234;
    if (st) zmodel = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(req, {31'h0, res_valid}, 32'h0);
    check("R5 hold", {16'h0, res}, {16'h0, last});
    check(req, {31'h0, zero_flag}, {31'h0, zmodel});
  endtask

  initial begin
    #(20 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #35;
    check("R6 res", {16'h0, res}, 32'h0);
    check("R6 res_valid", {31'h0, res_valid}, 32'h0);
    check("R6 zero_flag", {31'h0, zero_flag}, 32'h1);
    rst_n = 1'b1;

    // R1: single-term codes on a pattern holding all eight input combinations
    send("R1 term0", 1'b1, 8'h01, 16'hFF00, 16'hF0F0, 16'hCCCC);
    check("R1 term0 value", {16'h0, res}, 32'h0003);
    send("R1 term7", 1'b0, 8'h80, 16'hFF00, 16'hF0F0, 16'hCCCC);
    check("R1 term7 value", {16'h0, res}, 32'hC000);
    send("R1 term2", 1'b0, 8'h04, 16'hFF00, 16'hF0F0, 16'hCCCC);
    check("R1 term2 value", {16'h0, res}, 32'h0030);
    send("R1 term5", 1'b0, 8'h20, 16'hFF00, 16'hF0F0, 16'hCCCC);
    check("R1 term5 value", {16'h0, res}, 32'h0C00);

    // R2: all codes, structured and pseudo-random inputs
    for (int f = 0; f < 256; f++) begin
      send("R2 struct", 1'b1, f[7:0], 16'hFF00, 16'hF0F0, 16'hCCCC);
      for (int k = 0; k < 3; k++) begin
        logic [15:0] ra, rb, rc;
        next16(); ra = lfsr; next16(); rb = lfsr; next16(); rc = lfsr;
        send("R2 random", 1'b0, f[7:0], ra, rb, rc);
      end
    end

    // R3 and R4
    for (int k = 0; k < 8; k++) begin
      logic [15:0] ra, rb, rc;
      next16(); ra = lfsr; next16(); rb = lfsr; next16(); rc = lfsr;
      send("R3", 1'b1, 8'h0A, ra, rb, rc);
      check("R3 notA_and_C", {16'h0, res}, {16'h0, ~ra & rc});
      send("R4 zeros", 1'b0, 8'h00, ra, rb, rc);
      check("R4 zeros value", {16'h0, res}, 32'h0);
      send("R4 ones", 1'b0, 8'hFF, ra, rb, rc);
      check("R4 ones value", {16'h0, res}, 32'hFFFF);
    end

    // R7/R8: collision test sequence with AND of A and B
    idle_cycle("R7 lone start", 1'b1);
    send("R8 no overlap", 1'b0, 8'hC0, 16'h00F0, 16'h0F00, 16'h0);
    check("R8 still set", {31'h0, zero_flag}, 32'h1);
    send("R8 overlap", 1'b0, 8'hC0, 16'h01F0, 16'h0F00, 16'h0);
    check("R8 cleared", {31'h0, zero_flag}, 32'h0);
    send("R8 sticky", 1'b0, 8'hC0, 16'h00F0, 16'h0F00, 16'h0);
    check("R8 stays clear", {31'h0, zero_flag}, 32'h0);
    idle_cycle("R9 idle keeps clear", 1'b0);
    idle_cycle("R7 start after clear", 1'b1);
    check("R7 set", {31'h0, zero_flag}, 32'h1);
    idle_cycle("R9 idle keeps set", 1'b0);
    send("R8 dirty", 1'b0, 8'hFF, 16'h0, 16'h0, 16'h0);
    send("R7 start with nonzero word", 1'b1, 8'hC0, 16'h8000, 16'h8000, 16'h0);
    check("R7 same cycle nonzero", {31'h0, zero_flag}, 32'h0);
    send("R7 start with zero word", 1'b1, 8'hC0, 16'h8000, 16'h0001, 16'h0);
    check("R7 same cycle zero", {31'h0, zero_flag}, 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule